// File: doc/BRIEF.md
# Indexed Framebuffer Control Registers

This block is the register side of an 8-bit indexed framebuffer. A host reaches it through a simple word bus that carries an address, write data, a write strobe and a read strobe. It holds the values a pixel pipeline needs to paint a frame:

- the visible width and height;
- a 32-bit control word, which holds the forced-blank flag, the cursor-disable flag and the pixel depth code;
- the start offset of the visible image in video memory;
- the cursor position;
- a 256-entry colour lookup table;
- a 3-entry cursor colour table;
- a 512-word cursor bitmap.

The pipeline reads each table through its own combinational lookup port.

The host programs the width in units of four pixels and the height in half-lines. The block stores both in pixels. The three tables are spread over the address map with one entry every 8 bytes. Raster timing offsets are accepted and have no effect. A write to one dedicated offset returns every register and table to zero. The block keeps a single interrupt line. It rises when the pipeline signals the end of a frame and drops on any bus write.

Read data and the error pulse appear on the clock edge after the access. An access to an offset that has no function returns zero and produces a one-cycle error pulse.

Top module: `fbctl_regs`

## Requirements
- R1: After reset, all stored values, all table entries, `bus_rdata`, `bus_err` and `irq` are zero.
- R2: A write to byte offset 0x118 sets the width to the written value times four (value bits DIM_W-3:0, shifted left by two). A read of 0x118 returns the width divided by four.
- R3: A write to 0x150 sets the height to the written value divided by two (value bits DIM_W:1). A read of 0x150 returns the height times two.
- R4: The control word at 0x300 is read/write.
  - Bit 10 drives `force_blank`.
  - Bit 23 drives `cursor_off`.
  - Bits 22:20 give the pixel depth: codes 0..5 map to 1, 2, 4, 8, 15 and 16 bits with `depth_ok`=1. Codes 6 and 7 give `depth_bits`=0 and `depth_ok`=0.
- R5: Offset 0x400 (image start offset, low TOP_W bits) and offset 0x638 (cursor position) are write-only.
  - The cursor position has X in data bits 23:12 and Y in bits 11:0.
  - A read of either offset returns zero and pulses `bus_err`.
- R6: The colour table covers 0x800..0xFFF, with entry (addr-0x800)>>3.
  - Each entry stores red from data bits 23:16, green from 15:8 and blue from 7:0, packed in that order.
  - Reads return the packed value, and `pal_rd_rgb` shows the entry chosen by `pal_rd_idx`.
- R7: The cursor colour table covers 0x508..0x51F, with entry (addr-0x508)>>3 (3 entries).
  - It uses the same packing as R6 and is readable.
  - A lookup index of 3 returns zero.
- R8: The cursor bitmap covers 0x1000..0x1FFF, with entry (addr-0x1000)>>3 (512 entries).
  - Each entry stores data bits 15:0.
  - Reads return the word zero-extended.
- R9: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change nothing and do not pulse `bus_err`.
- R10: A write to 0x100000 clears all registers, all three tables and `irq` on that clock edge.
- R11: A `frame_end` pulse sets `irq`, and any bus write clears it. When both occur in the same cycle, the write wins.
- R12: On an unmapped access, `bus_err` is high for exactly the one cycle after the access.
  - A read of an unmapped offset returns zero.
  - A write to an unmapped offset changes nothing.
  - A mapped access does not raise `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 21 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after `bus_re` |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| frame_end | input | 1 | End-of-frame pulse from the pixel pipeline |
| irq | output | 1 | Frame interrupt |
| disp_width | output | DIM_W | Width in pixels |
| disp_height | output | DIM_W | Height in lines |
| ctrl_word | output | 32 | Control word |
| force_blank | output | 1 | Forced blank flag |
| cursor_off | output | 1 | Cursor disabled flag |
| depth_bits | output | 5 | Decoded pixel depth |
| depth_ok | output | 1 | Depth code is valid |
| top_offset | output | TOP_W | Image start offset in video memory |
| cursor_x | output | 12 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| pal_rd_idx | input | 8 | Colour table lookup index |
| pal_rd_rgb | output | 24 | Colour table entry |
| cpal_rd_idx | input | 2 | Cursor colour lookup index |
| cpal_rd_rgb | output | 24 | Cursor colour entry |
| pat_rd_idx | input | 9 | Cursor bitmap lookup index |
| pat_rd_word | output | 16 | Cursor bitmap word |

## Verification
On every cycle, the bound checker checks the following:
- the interrupt rules (a write clears it, a lone frame pulse sets it);
- that `bus_err` never pulses without an access;
- the pixel-unit scaling of width and height writes;
- the effect of the clear offset;
- that a write to the boot timing offset leaves the stored values untouched.

Other behaviour needs the bench's directed scenarios:
- table contents and address aliasing inside an 8-byte stride;
- read-back packing and the write-only offsets;
- the full list of ignored timing offsets;
- the depth code table.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;
   localparam int unsigned ADDR_W = 21;

   typedef enum logic [3:0] {
      RG_NONE, RG_IGNORE, RG_HDISP, RG_VDISP, RG_CTRL, RG_TOP,
      RG_CPOS, RG_CPAL, RG_PAL, RG_PAT, RG_RESET
   } fb_region_e;

   localparam logic [ADDR_W-1:0] A_BOOT    = 21'h000000;
   localparam logic [ADDR_W-1:0] A_HDISP   = 21'h000118;
   localparam logic [ADDR_W-1:0] A_VDISP   = 21'h000150;
   localparam logic [ADDR_W-1:0] A_CTRL    = 21'h000300;
   localparam logic [ADDR_W-1:0] A_TOP     = 21'h000400;
   localparam logic [ADDR_W-1:0] A_CPOS    = 21'h000638;
   localparam logic [ADDR_W-1:0] A_CPAL_LO = 21'h000508;
   localparam logic [ADDR_W-1:0] A_CPAL_HI = 21'h00051F;
   localparam logic [ADDR_W-1:0] A_PAL_LO  = 21'h000800;
   localparam logic [ADDR_W-1:0] A_PAL_HI  = 21'h000FFF;
   localparam logic [ADDR_W-1:0] A_PAT_LO  = 21'h001000;
   localparam logic [ADDR_W-1:0] A_PAT_HI  = 21'h001FFF;
   localparam logic [ADDR_W-1:0] A_CLEAR   = 21'h100000;

   // control word field positions
   localparam int unsigned CW_BLANK  = 10;
   localparam int unsigned CW_NOCURS = 23;
   localparam int unsigned CW_DEPTH  = 20;

   // returns {valid, bits[4:0]}
   function automatic logic [5:0] depth_decode(input logic [2:0] code);
      case (code)
         3'd0:    return {1'b1, 5'd1};
         3'd1:    return {1'b1, 5'd2};
         3'd2:    return {1'b1, 5'd4};
         3'd3:    return {1'b1, 5'd8};
         3'd4:    return {1'b1, 5'd15};
         3'd5:    return {1'b1, 5'd16};
         default: return 6'd0;
      endcase
   endfunction
endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
   import fbctl_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output fb_region_e        region,
   output logic [8:0]        idx
);
   always_comb begin
      region = RG_NONE;
      idx    = '0;
      if (addr >= A_PAL_LO && addr <= A_PAL_HI) begin
         region = RG_PAL;
         idx    = {1'b0, addr[10:3]};
      end else if (addr >= A_PAT_LO && addr <= A_PAT_HI) begin
         region = RG_PAT;
         idx    = addr[11:3];
      end else if (addr >= A_CPAL_LO && addr <= A_CPAL_HI) begin
         region = RG_CPAL;
         // window base is 8-byte aligned, so the slot is bits 4:3 minus one
         idx    = {7'd0, addr[4:3] - 2'd1};
      end else begin
         case (addr)
            A_HDISP: region = RG_HDISP;
            A_VDISP: region = RG_VDISP;
            A_CTRL:  region = RG_CTRL;
            A_TOP:   region = RG_TOP;
            A_CPOS:  region = RG_CPOS;
            A_CLEAR: region = RG_RESET;
            A_BOOT, 21'h108, 21'h110, 21'h120, 21'h128, 21'h130, 21'h138,
            21'h140, 21'h148, 21'h158, 21'h160, 21'h168, 21'h170, 21'h200:
                     region = RG_IGNORE;
            default: region = RG_NONE;
         endcase
      end
   end
endmodule

// File: rtl/fbctl_table.sv
module fbctl_table #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned DATA_W = 24,
   parameter int unsigned IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [IDX_W-1:0]  ridx_b,
   output logic [DATA_W-1:0] rdata_b
);
   localparam int unsigned SLOTS = 2 ** IDX_W;

   if (DEPTH > SLOTS) begin : g_bad_depth
      $error("fbctl_table: DEPTH exceeds index range");
   end

   logic [DATA_W-1:0] ent [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [DATA_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        ent_q <= '0;
         else if (clr)                      ent_q <= '0;
         else if (we && widx == IDX_W'(e))  ent_q <= wdata;
      end
      assign ent[e] = ent_q;
   end

   if (DEPTH == SLOTS) begin : g_full
      assign rdata_a = ent[ridx_a];
      assign rdata_b = ent[ridx_b];
   end else begin : g_guarded
      assign rdata_a = (32'(ridx_a) < DEPTH) ? ent[ridx_a] : '0;
      assign rdata_b = (32'(ridx_b) < DEPTH) ? ent[ridx_b] : '0;
   end
endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
   import fbctl_pkg::*;
#(
   parameter int unsigned DIM_W     = 12,
   parameter int unsigned TOP_W     = 23,
   parameter int unsigned PAL_DEPTH = 256,
   parameter int unsigned PAT_DEPTH = 512,
   localparam int unsigned PAL_IW   = $clog2(PAL_DEPTH),
   localparam int unsigned PAT_IW   = $clog2(PAT_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   input  logic               bus_we,
   input  logic               bus_re,
   output logic [31:0]        bus_rdata,
   output logic               bus_err,
   input  logic               frame_end,
   output logic               irq,
   output logic [DIM_W-1:0]   disp_width,
   output logic [DIM_W-1:0]   disp_height,
   output logic [31:0]        ctrl_word,
   output logic               force_blank,
   output logic               cursor_off,
   output logic [4:0]         depth_bits,
   output logic               depth_ok,
   output logic [TOP_W-1:0]   top_offset,
   output logic [11:0]        cursor_x,
   output logic [11:0]        cursor_y,
   input  logic [PAL_IW-1:0]  pal_rd_idx,
   output logic [23:0]        pal_rd_rgb,
   input  logic [1:0]         cpal_rd_idx,
   output logic [23:0]        cpal_rd_rgb,
   input  logic [PAT_IW-1:0]  pat_rd_idx,
   output logic [15:0]        pat_rd_word
);
   localparam int unsigned RB_W = DIM_W - 2;   // width read-back field
   localparam int unsigned HB_W = DIM_W + 1;   // height read-back field

   if (DIM_W < 4 || DIM_W > 30) begin : g_bad_dim
      $error("fbctl_regs: DIM_W out of range");
   end
   if (TOP_W < 1 || TOP_W > 32) begin : g_bad_top
      $error("fbctl_regs: TOP_W out of range");
   end
   if (PAL_DEPTH > 256 || PAT_DEPTH > 512 || PAL_DEPTH < 2 || PAT_DEPTH < 2) begin : g_bad_tab
      $error("fbctl_regs: table depth does not fit its address window");
   end

   fb_region_e rg;
   logic [8:0] rg_idx;

   fbctl_decode u_dec (.addr(bus_addr), .region(rg), .idx(rg_idx));

   logic do_clr, rd_ok;
   assign do_clr = bus_we && (rg == RG_RESET);
   assign rd_ok  = rg inside {RG_HDISP, RG_VDISP, RG_CTRL, RG_CPAL, RG_PAL, RG_PAT};

   logic [DIM_W-1:0] width_q, height_q;
   logic [31:0]      ctrl_q;
   logic [TOP_W-1:0] top_q;
   logic [23:0]      pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || do_clr) begin
         width_q  <= '0;
         height_q <= '0;
         ctrl_q   <= '0;
         top_q    <= '0;
         pos_q    <= '0;
      end else if (bus_we) begin
         case (rg)
            RG_HDISP: width_q  <= {bus_wdata[DIM_W-3:0], 2'b00};
            RG_VDISP: height_q <= bus_wdata[DIM_W:1];
            RG_CTRL:  ctrl_q   <= bus_wdata;
            RG_TOP:   top_q    <= bus_wdata[TOP_W-1:0];
            RG_CPOS:  pos_q    <= bus_wdata[23:0];
            default:  ;
         endcase
      end
   end

   logic [23:0] pal_bus, cpal_bus;
   logic [15:0] pat_bus;

   fbctl_table #(.DEPTH(PAL_DEPTH), .DATA_W(24), .IDX_W(PAL_IW)) u_pal (
      .clk(clk), .rst_n(rst_n), .clr(do_clr),
      .we(bus_we && rg == RG_PAL), .widx(rg_idx[PAL_IW-1:0]), .wdata(bus_wdata[23:0]),
      .ridx_a(rg_idx[PAL_IW-1:0]), .rdata_a(pal_bus),
      .ridx_b(pal_rd_idx), .rdata_b(pal_rd_rgb));

   fbctl_table #(.DEPTH(3), .DATA_W(24), .IDX_W(2)) u_cpal (
      .clk(clk), .rst_n(rst_n), .clr(do_clr),
      .we(bus_we && rg == RG_CPAL), .widx(rg_idx[1:0]), .wdata(bus_wdata[23:0]),
      .ridx_a(rg_idx[1:0]), .rdata_a(cpal_bus),
      .ridx_b(cpal_rd_idx), .rdata_b(cpal_rd_rgb));

   fbctl_table #(.DEPTH(PAT_DEPTH), .DATA_W(16), .IDX_W(PAT_IW)) u_pat (
      .clk(clk), .rst_n(rst_n), .clr(do_clr),
      .we(bus_we && rg == RG_PAT), .widx(rg_idx[PAT_IW-1:0]), .wdata(bus_wdata[15:0]),
      .ridx_a(rg_idx[PAT_IW-1:0]), .rdata_a(pat_bus),
      .ridx_b(pat_rd_idx), .rdata_b(pat_rd_word));

   logic [31:0] rd_val;
   always_comb begin
      case (rg)
         RG_HDISP: rd_val = {{(32-RB_W){1'b0}}, width_q[DIM_W-1:2]};
         RG_VDISP: rd_val = {{(32-HB_W){1'b0}}, height_q, 1'b0};
         RG_CTRL:  rd_val = ctrl_q;
         RG_CPAL:  rd_val = {8'd0, cpal_bus};
         RG_PAL:   rd_val = {8'd0, pal_bus};
         RG_PAT:   rd_val = {16'd0, pat_bus};
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
         irq       <= 1'b0;
      end else begin
         if (bus_re) bus_rdata <= rd_ok ? rd_val : '0;
         bus_err <= (bus_we && rg == RG_NONE) || (bus_re && !rd_ok);
         if (bus_we)         irq <= 1'b0;
         else if (frame_end) irq <= 1'b1;
      end
   end

   assign disp_width  = width_q;
   assign disp_height = height_q;
   assign ctrl_word   = ctrl_q;
   assign force_blank = ctrl_q[CW_BLANK];
   assign cursor_off  = ctrl_q[CW_NOCURS];
   assign {depth_ok, depth_bits} = depth_decode(ctrl_q[CW_DEPTH +: 3]);
   assign top_offset  = top_q;
   assign cursor_x    = pos_q[23:12];
   assign cursor_y    = pos_q[11:0];
endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk
   import fbctl_pkg::*;
#(
   parameter int unsigned DIM_W = 12,
   parameter int unsigned TOP_W = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_we,
   input logic              bus_re,
   input logic              bus_err,
   input logic              frame_end,
   input logic              irq,
   input logic [DIM_W-1:0]  disp_width,
   input logic [DIM_W-1:0]  disp_height,
   input logic [31:0]       ctrl_word,
   input logic [TOP_W-1:0]  top_offset,
   input logic [11:0]       cursor_x,
   input logic [11:0]       cursor_y
);
   a_r11_write_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |=> !irq);

   a_r11_frame_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !bus_we) |=> irq);

   a_r12_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we || bus_re) |=> !bus_err);

   a_r2_width_scaled: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_HDISP) |=>
         disp_width == {$past(bus_wdata[DIM_W-3:0]), 2'b00});

   a_r3_height_scaled: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_VDISP) |=>
         disp_height == $past(bus_wdata[DIM_W:1]));

   a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_CLEAR) |=>
         (ctrl_word == '0 && disp_width == '0 && disp_height == '0 &&
          top_offset == '0 && cursor_x == '0 && cursor_y == '0 && !irq));

   a_r9_boot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_BOOT) |=>
         ($stable(ctrl_word) && $stable(disp_width) && $stable(disp_height) &&
          $stable(top_offset) && !bus_err));
endmodule

bind fbctl_regs fbctl_regs_chk #(.DIM_W(DIM_W), .TOP_W(TOP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_we(bus_we), .bus_re(bus_re), .bus_err(bus_err), .frame_end(frame_end),
   .irq(irq), .disp_width(disp_width), .disp_height(disp_height),
   .ctrl_word(ctrl_word), .top_offset(top_offset),
   .cursor_x(cursor_x), .cursor_y(cursor_y));

// File: tb/fbctl_regs_bench.sv
`timescale 1ns/1ps
module fbctl_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [20:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0, bus_re = 1'b0, frame_end = 1'b0;
   logic [31:0] bus_rdata, ctrl_word;
   logic        bus_err, irq, force_blank, cursor_off, depth_ok;
   logic [11:0] disp_width, disp_height, cursor_x, cursor_y;
   logic [4:0]  depth_bits;
   logic [22:0] top_offset;
   logic [7:0]  pal_rd_idx = '0;
   logic [23:0] pal_rd_rgb, cpal_rd_rgb;
   logic [1:0]  cpal_rd_idx = '0;
   logic [8:0]  pat_rd_idx = '0;
   logic [15:0] pat_rd_word;

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   fbctl_regs u_fbctl_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .frame_end(frame_end), .irq(irq), .disp_width(disp_width),
      .disp_height(disp_height), .ctrl_word(ctrl_word), .force_blank(force_blank),
      .cursor_off(cursor_off), .depth_bits(depth_bits), .depth_ok(depth_ok),
      .top_offset(top_offset), .cursor_x(cursor_x), .cursor_y(cursor_y),
      .pal_rd_idx(pal_rd_idx), .pal_rd_rgb(pal_rd_rgb),
      .cpal_rd_idx(cpal_rd_idx), .cpal_rd_rgb(cpal_rd_rgb),
      .pat_rd_idx(pat_rd_idx), .pat_rd_word(pat_rd_word));

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [20:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [20:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata; e = bus_err;
   endtask

   task automatic t_reset();
      chk("R1", "width", 32'(disp_width), 0);
      chk("R1", "height", 32'(disp_height), 0);
      chk("R1", "ctrl", ctrl_word, 0);
      chk("R1", "top", 32'(top_offset), 0);
      chk("R1", "cursor", {8'd0, cursor_x, cursor_y}, 0);
      chk("R1", "irq/err", {30'd0, irq, bus_err}, 0);
      chk("R1", "rdata", bus_rdata, 0);
      pal_rd_idx = 8'd77; pat_rd_idx = 9'd300; cpal_rd_idx = 2'd1;
      #0.1;
      chk("R1", "tables", {pal_rd_rgb, 8'd0} | cpal_rd_rgb | 32'(pat_rd_word), 0);
   endtask

   task automatic t_dims();
      logic [31:0] d; logic e;
      wr(21'h118, 32'h50);
      chk("R2", "width", 32'(disp_width), 32'd320);
      rd(21'h118, d, e);
      chk("R2", "width read", d, 32'h50);
      chk("R2", "width read err", 32'(e), 0);
      wr(21'h118, 32'hFFFF_F3FF);
      chk("R2", "width truncated", 32'(disp_width), 32'hFFC);
      wr(21'h150, 32'h1E1);
      chk("R3", "height", 32'(disp_height), 32'd240);
      rd(21'h150, d, e);
      chk("R3", "height read", d, 32'h1E0);
   endtask

   task automatic t_ctrl();
      logic [31:0] d; logic e;
      wr(21'h300, 32'h00B0_0400);
      chk("R4", "blank/cursoroff", {30'd0, force_blank, cursor_off}, 32'd3);
      chk("R4", "depth code3", {26'd0, depth_ok, depth_bits}, {26'd0, 1'b1, 5'd8});
      rd(21'h300, d, e);
      chk("R4", "ctrl read", d, 32'h00B0_0400);
      for (int c = 0; c < 8; c++) begin
         logic [5:0] exp;
         case (c)
            0: exp = {1'b1, 5'd1};  1: exp = {1'b1, 5'd2};
            2: exp = {1'b1, 5'd4};  3: exp = {1'b1, 5'd8};
            4: exp = {1'b1, 5'd15}; 5: exp = {1'b1, 5'd16};
            default: exp = 6'd0;
         endcase
         wr(21'h300, 32'(c) << 20);
         chk("R4", "depth decode", {26'd0, depth_ok, depth_bits}, {26'd0, exp});
      end
      chk("R4", "flags clear", {30'd0, force_blank, cursor_off}, 0);
   endtask

   task automatic t_wronly();
      logic [31:0] d; logic e;
      wr(21'h400, 32'h0012_3456);
      chk("R5", "top", 32'(top_offset), 32'h12_3456);
      wr(21'h638, 32'h000A_503C);
      chk("R5", "cursor x", 32'(cursor_x), 32'h0A5);
      chk("R5", "cursor y", 32'(cursor_y), 32'h03C);
      rd(21'h400, d, e);
      chk("R5", "top read", {d[30:0], e}, 32'd1);
      rd(21'h638, d, e);
      chk("R5", "pos read", {d[30:0], e}, 32'd1);
   endtask

   task automatic t_pal();
      logic [31:0] d; logic e;
      wr(21'h828, 32'hFF11_2233);
      wr(21'hFF8, 32'hFFAA_BBCC);
      pal_rd_idx = 8'd5; #0.1;
      chk("R6", "lookup 5", 32'(pal_rd_rgb), 32'h112233);
      pal_rd_idx = 8'd255; #0.1;
      chk("R6", "lookup 255", 32'(pal_rd_rgb), 32'hAABBCC);
      pal_rd_idx = 8'd4; #0.1;
      chk("R6", "neighbour 4", 32'(pal_rd_rgb), 0);
      rd(21'h82C, d, e);
      chk("R6", "alias read", d, 32'h112233);
   endtask

   task automatic t_cpal();
      logic [31:0] d; logic e;
      wr(21'h518, 32'h0044_5566);
      wr(21'h508, 32'h0001_0203);
      rd(21'h51C, d, e);
      chk("R7", "read slot2", d, 32'h445566);
      cpal_rd_idx = 2'd2; #0.1;
      chk("R7", "lookup 2", 32'(cpal_rd_rgb), 32'h445566);
      cpal_rd_idx = 2'd0; #0.1;
      chk("R7", "lookup 0", 32'(cpal_rd_rgb), 32'h010203);
      cpal_rd_idx = 2'd1; #0.1;
      chk("R7", "lookup 1", 32'(cpal_rd_rgb), 0);
      cpal_rd_idx = 2'd3; #0.1;
      chk("R7", "lookup 3", 32'(cpal_rd_rgb), 0);
   endtask

   task automatic t_pat();
      logic [31:0] d; logic e;
      wr(21'h1FF8, 32'hDEAD_BEEF);
      wr(21'h1000, 32'h0000_1234);
      rd(21'h1FF8, d, e);
      chk("R8", "read 511", d, 32'h0000_BEEF);
      pat_rd_idx = 9'd511; #0.1;
      chk("R8", "lookup 511", 32'(pat_rd_word), 32'hBEEF);
      pat_rd_idx = 9'd0; #0.1;
      chk("R8", "lookup 0", 32'(pat_rd_word), 32'h1234);
   endtask

   function automatic logic [20:0] timing_addr(int k);
      case (k)
         0: return 21'h000;  1: return 21'h108;  2: return 21'h110;
         3: return 21'h120;  4: return 21'h128;  5: return 21'h130;
         6: return 21'h138;  7: return 21'h140;  8: return 21'h148;
         9: return 21'h158; 10: return 21'h160; 11: return 21'h168;
         12: return 21'h170; default: return 21'h200;
      endcase
   endfunction

   task automatic t_ignore();
      logic [31:0] c0; logic [11:0] w0, h0; logic [22:0] t0; logic [23:0] p0;
      int bad = 0;
      c0 = ctrl_word; w0 = disp_width; h0 = disp_height; t0 = top_offset;
      p0 = {cursor_x, cursor_y};
      for (int k = 0; k < 14; k++) begin
         wr(timing_addr(k), 32'hFFFF_FFFF);
         if (bus_err) bad++;
      end
      chk("R9", "no err", 32'(bad), 0);
      chk("R9", "ctrl kept", ctrl_word, c0);
      chk("R9", "dims kept", {8'd0, disp_width, disp_height}, {8'd0, w0, h0});
      chk("R9", "top/pos kept", 32'(top_offset) ^ 32'(p0), 32'(t0) ^ 32'(p0));
      chk("R9", "pos kept", 32'({cursor_x, cursor_y}), 32'(p0));
   endtask

   task automatic t_unmapped();
      logic [31:0] d, c0; logic e;
      c0 = ctrl_word;
      wr(21'h310, 32'hFFFF_FFFF);
      chk("R12", "write err", 32'(bus_err), 1);
      chk("R12", "ctrl kept", ctrl_word, c0);
      @(negedge clk);
      chk("R12", "err one cycle", 32'(bus_err), 0);
      rd(21'h0F_0000, d, e);
      chk("R12", "read data", d, 0);
      chk("R12", "read err", 32'(e), 1);
      rd(21'h300, d, e);
      chk("R12", "mapped read no err", 32'(e), 0);
   endtask

   task automatic t_irq();
      @(negedge clk); frame_end = 1'b1;
      @(negedge clk); frame_end = 1'b0;
      chk("R11", "raised", 32'(irq), 1);
      @(negedge clk);
      chk("R11", "held", 32'(irq), 1);
      wr(21'h200, 32'h0);
      chk("R11", "write lowers", 32'(irq), 0);
      @(negedge clk); frame_end = 1'b1; bus_addr = 21'h300; bus_wdata = ctrl_word; bus_we = 1'b1;
      @(negedge clk); frame_end = 1'b0; bus_we = 1'b0;
      chk("R11", "write wins", 32'(irq), 0);
   endtask

   task automatic t_clear();
      logic [31:0] d; logic e;
      @(negedge clk); frame_end = 1'b1;
      @(negedge clk); frame_end = 1'b0;
      wr(21'h100000, 32'h0);
      chk("R10", "irq", 32'(irq), 0);
      chk("R10", "regs", ctrl_word | 32'(disp_width) | 32'(disp_height) |
                         32'(top_offset) | 32'({cursor_x, cursor_y}), 0);
      pal_rd_idx = 8'd5; cpal_rd_idx = 2'd2; pat_rd_idx = 9'd511; #0.1;
      chk("R10", "tables", 32'(pal_rd_rgb) | 32'(cpal_rd_rgb) | 32'(pat_rd_word), 0);
      rd(21'h51C, d, e);
      chk("R10", "cpal read", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dims();
      t_ctrl();
      t_wronly();
      t_pal();
      t_cpal();
      t_pat();
      t_ignore();
      t_unmapped();
      t_irq();
      t_clear();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule